// File: doc/BRIEF.md
# Temporal Stream Prefetch Engine

This block replays a previously recorded sequence of cache-miss addresses once an external index lookup has produced a pointer into the circular miss log. It reads the log in blocks of consecutive entries and keeps a FIFO address queue topped up. Queued addresses are issued as prefetches strictly in order, with a small number outstanding at once. Returned lines are parked in a small fully-associative prefetch buffer, kept apart from the cache hierarchy. A demand miss from the L1 that finds its line there is served from the buffer, and the entry is dropped. Each consumed address drains the queue, and the queue then asks for the next log block, so one lookup can drive a stream of any length.

Any log entry may carry a stream-end flag. When such an entry reaches the head of the queue, issue stops. The engine waits there until the core itself demands that exact address, then pops it and carries on. A new trigger pointer arriving at any time abandons the current stream. A log read already in flight is then thrown away when it returns.

Top module: `stream_prefetch_engine`

## Requirements
- R1: After reset, and until the first trigger, the engine issues no log read and no prefetch, and reports no demand hit.
- R2: A trigger empties the address queue at once. The next log read uses the trigger pointer. A log response belonging to a read issued before the trigger is discarded.
- R3: A log read fetches 4 consecutive entries starting at `log_req_ptr`. Entry i sits in `log_rsp_addr[i*ADDR_W +: ADDR_W]`, and its stream-end flag is `log_rsp_end[i]`. Entry 0 is pushed first. The pointer advances by 4 per read and wraps at the pointer width. A read is requested only while streaming, with no read outstanding and queue occupancy of 4 or fewer. The 16-entry queue never overflows.
- R4: Prefetches leave in queue order, at most one per cycle, and only while fewer than 4 are outstanding. `pf_req_tag` is the lowest-numbered free slot in 0..3.
- R5: Prefetch responses may return in any order, identified by tag. The returned line is stored for the address issued under that tag, and a later demand hit returns exactly that data.
- R6: A demand whose address is in the buffer gives `dmd_hit`=1 and the line on `dmd_data` in the following cycle, and it invalidates the entry. A repeated demand for the same address misses.
- R7: The buffer holds 32 lines. A free entry is always used first. When the buffer is full, an insertion evicts the line that was inserted longest ago, and a later demand for that address misses.
- R8: While the queue head carries the stream-end flag, no prefetch is issued. A demand for exactly that address pops the head, and issue may resume in the next cycle. Demands for other addresses leave the head in place.
- R9: When a demand hit and a prefetch insertion fall in the same cycle, both take effect. The entry freed by the hit counts as free, so that insertion evicts nothing.
- R10: A demand looks up the buffer as it stood before any insertion in the same cycle. A demand for the address whose line is arriving in that cycle misses, and the line is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | New stream start pointer from the index lookup |
| trig_ptr | input | PTR_W | Log pointer of the first entry of the new stream |
| log_req_valid | output | 1 | Log block read request (always accepted) |
| log_req_ptr | output | PTR_W | First log entry of the requested block |
| log_rsp_valid | input | 1 | Log block read data valid |
| log_rsp_addr | input | BLK*ADDR_W | Block of log addresses, entry i in slice i |
| log_rsp_end | input | BLK | Stream-end flag per log entry |
| pf_req_valid | output | 1 | Prefetch request (always accepted) |
| pf_req_addr | output | ADDR_W | Line address to prefetch |
| pf_req_tag | output | TW | Outstanding slot carrying this prefetch |
| pf_rsp_valid | input | 1 | Prefetch line returned |
| pf_rsp_tag | input | TW | Slot of the returned prefetch |
| pf_rsp_data | input | DATA_W | Returned line data |
| dmd_valid | input | 1 | L1 demand miss lookup |
| dmd_addr | input | ADDR_W | Demanded line address |
| dmd_hit | output | 1 | Previous cycle's demand was served from the buffer |
| dmd_data | output | DATA_W | Line data for a demand hit |

## Verification
Two collisions matter most here. The first is a demand hit that frees a buffer entry in the same cycle as a prefetch response fills one. The second is a demand that names the very line being returned in that cycle. The bench drives demands from the state of its reference model, sometimes choosing the address of the response it is driving in that cycle, so both cases occur many times while the buffer is full. The hit, its data and any later miss on an evicted line are compared every clock against the behavioural model. That model removes the hit line first, then inserts the new one, and drops the oldest line only if the buffer is still full.

// File: rtl/spe_pkg.sv
package spe_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_STREAM = 1'b1} stream_state_e;

  // index of the lowest set bit among the first n bits, n when none is set
  function automatic int unsigned first_set(input logic [63:0] vec, input int unsigned n);
    int unsigned idx;
    idx = n;
    for (int i = 63; i >= 0; i--) begin
      if (i < int'(n) && vec[i]) idx = i;
    end
    return idx;
  endfunction

  // rank of an entry after one removal above it and an optional insertion
  function automatic int unsigned next_rank(input int unsigned rank, input bit drop_above,
                                            input int unsigned dropped, input bit added);
    int unsigned r;
    r = rank;
    if (drop_above && rank > dropped) r = r - 1;
    if (added) r = r + 1;
    return r;
  endfunction

endpackage

// File: rtl/spe_addr_queue.sv
module spe_addr_queue #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  parameter int BLK   = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [BLK*AW-1:0] push_addr,
  input  logic [BLK-1:0]    push_end,
  input  logic              pop,
  output logic              head_valid,
  output logic [AW-1:0]     head_addr,
  output logic              head_end,
  output logic [CW-1:0]     count
);
  localparam int IW = $clog2(DEPTH);

  logic [AW-1:0]    a_mem [DEPTH];
  logic [DEPTH-1:0] e_mem;
  logic [IW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign do_push = push && !flush;
  assign do_pop  = pop && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_pop)  rd_q <= rd_q + IW'(1);
      if (do_push) wr_q <= wr_q + IW'(BLK);
      cnt_q <= cnt_q + (do_push ? CW'(BLK) : CW'(0)) - (do_pop ? CW'(1) : CW'(0));
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      for (int i = 0; i < BLK; i++) begin
        a_mem[wr_q + IW'(i)] <= push_addr[i*AW +: AW];
        e_mem[wr_q + IW'(i)] <= push_end[i];
      end
    end
  end

  assign head_valid = (cnt_q != '0);
  assign head_addr  = a_mem[rd_q];
  assign head_end   = e_mem[rd_q];
  assign count      = cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |-> (int'(cnt_q) + BLK <= DEPTH + (do_pop ? 1 : 0)));

  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |-> head_valid);

endmodule

// File: rtl/spe_slot_track.sv
module spe_slot_track
  import spe_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NOUT = 4,
  localparam int TW  = $clog2(NOUT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  output logic [TW-1:0] free_tag,
  output logic          free_any,
  input  logic          rsp_valid,
  input  logic [TW-1:0] rsp_tag,
  output logic [AW-1:0] rsp_addr
);
  logic [NOUT-1:0] busy_q;
  logic [AW-1:0]   addr_q [NOUT];

  assign free_any = |(~busy_q);
  assign free_tag = TW'(first_set(64'(~busy_q), NOUT));
  assign rsp_addr = addr_q[rsp_tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else begin
      if (rsp_valid) busy_q[rsp_tag]  <= 1'b0;
      if (issue)     busy_q[free_tag] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (issue) addr_q[free_tag] <= issue_addr;
  end

  assert_credit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> free_any);

  assert_rsp_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy_q[rsp_tag]);

  assert_slot_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !(rsp_valid && rsp_tag == free_tag)) |=> busy_q[$past(free_tag)]);

endmodule

// File: rtl/spe_pf_buffer.sv
module spe_pf_buffer
  import spe_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 512,
  parameter int NBUF = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic [DW-1:0] ins_data,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  localparam int SW  = $clog2(NBUF);
  localparam int AGW = $clog2(NBUF);

  logic [NBUF-1:0] valid_q;
  logic [AW-1:0]   tag_q  [NBUF];
  logic [DW-1:0]   data_q [NBUF];
  logic [AGW-1:0]  age_q  [NBUF];

  logic [NBUF-1:0] match, free_vec;
  logic [SW-1:0]   hit_idx, vic_idx, ins_slot;
  logic [AGW-1:0]  hit_age;

  always_comb begin
    for (int i = 0; i < NBUF; i++) match[i] = valid_q[i] && (tag_q[i] == lk_addr);
  end

  assign hit      = lk_valid && (|match);
  assign hit_idx  = SW'(first_set(64'(match), NBUF));
  assign hit_data = data_q[hit_idx];
  assign hit_age  = age_q[hit_idx];
  assign free_vec = ~valid_q | (hit ? match : '0);

  // oldest line: rank NBUF-1, only meaningful when every entry is valid
  always_comb begin
    vic_idx = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (valid_q[i] && age_q[i] == AGW'(NBUF - 1)) vic_idx = SW'(i);
    end
  end

  assign ins_slot = (|free_vec) ? SW'(first_set(64'(free_vec), NBUF)) : vic_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < NBUF; i++) age_q[i] <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (ins_valid && ins_slot == SW'(i)) begin
          valid_q[i] <= 1'b1;
          age_q[i]   <= '0;
        end else if (hit && match[i]) begin
          valid_q[i] <= 1'b0;
        end else if (valid_q[i]) begin
          age_q[i] <= AGW'(next_rank(int'(age_q[i]), hit, int'(hit_age), ins_valid));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid) begin
      tag_q[ins_slot]  <= ins_addr;
      data_q[ins_slot] <= ins_data;
    end
  end

  assert_hit_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(match));

  assert_invalidate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ins_valid) |=> ($countones(valid_q) == $past($countones(valid_q)) - 1));

  assert_no_evict_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ins_valid) |=> ($countones(valid_q) == $past($countones(valid_q))));

endmodule

// File: rtl/stream_prefetch_engine.sv
module stream_prefetch_engine
  import spe_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PTR_W    = 12,
  parameter int DATA_W   = 512,
  parameter int QDEPTH   = 16,
  parameter int BLK      = 4,
  parameter int LOW_MARK = 4,
  parameter int NBUF     = 32,
  parameter int NOUT     = 4,
  localparam int TW      = $clog2(NOUT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_valid,
  input  logic [PTR_W-1:0]      trig_ptr,
  output logic                  log_req_valid,
  output logic [PTR_W-1:0]      log_req_ptr,
  input  logic                  log_rsp_valid,
  input  logic [BLK*ADDR_W-1:0] log_rsp_addr,
  input  logic [BLK-1:0]        log_rsp_end,
  output logic                  pf_req_valid,
  output logic [ADDR_W-1:0]     pf_req_addr,
  output logic [TW-1:0]         pf_req_tag,
  input  logic                  pf_rsp_valid,
  input  logic [TW-1:0]         pf_rsp_tag,
  input  logic [DATA_W-1:0]     pf_rsp_data,
  input  logic                  dmd_valid,
  input  logic [ADDR_W-1:0]     dmd_addr,
  output logic                  dmd_hit,
  output logic [DATA_W-1:0]     dmd_data
);
  localparam int CW = $clog2(QDEPTH + 1);

  stream_state_e     state_q;
  logic              pend_q, discard_q;
  logic [PTR_W-1:0]  ptr_q;

  logic              q_head_valid, q_head_end;
  logic [ADDR_W-1:0] q_head_addr;
  logic [CW-1:0]     q_count;
  logic [TW-1:0]     free_tag;
  logic              free_any;
  logic [ADDR_W-1:0] rsp_addr;
  logic              buf_hit;
  logic [DATA_W-1:0] buf_data;
  logic              dmd_hit_q;
  logic [DATA_W-1:0] dmd_data_q;

  // named internal events
  logic ev_issue, ev_resume, ev_push, ev_flush, ev_logreq;

  assign ev_logreq = (state_q == ST_STREAM) && !pend_q && (q_count <= CW'(LOW_MARK));
  assign ev_issue  = (state_q == ST_STREAM) && q_head_valid && !q_head_end && free_any;
  assign ev_resume = dmd_valid && q_head_valid && q_head_end && (dmd_addr == q_head_addr);
  assign ev_push   = log_rsp_valid && !discard_q && !trig_valid;
  assign ev_flush  = trig_valid;

  spe_addr_queue #(.AW(ADDR_W), .DEPTH(QDEPTH), .BLK(BLK)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(ev_flush), .push(ev_push),
    .push_addr(log_rsp_addr), .push_end(log_rsp_end), .pop(ev_issue || ev_resume),
    .head_valid(q_head_valid), .head_addr(q_head_addr), .head_end(q_head_end),
    .count(q_count));

  spe_slot_track #(.AW(ADDR_W), .NOUT(NOUT)) u_slots (
    .clk(clk), .rst_n(rst_n), .issue(ev_issue), .issue_addr(q_head_addr),
    .free_tag(free_tag), .free_any(free_any), .rsp_valid(pf_rsp_valid),
    .rsp_tag(pf_rsp_tag), .rsp_addr(rsp_addr));

  spe_pf_buffer #(.AW(ADDR_W), .DW(DATA_W), .NBUF(NBUF)) u_buf (
    .clk(clk), .rst_n(rst_n), .ins_valid(pf_rsp_valid), .ins_addr(rsp_addr),
    .ins_data(pf_rsp_data), .lk_valid(dmd_valid), .lk_addr(dmd_addr),
    .hit(buf_hit), .hit_data(buf_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pend_q    <= 1'b0;
      discard_q <= 1'b0;
      ptr_q     <= '0;
    end else begin
      if (ev_logreq)          pend_q <= 1'b1;
      else if (log_rsp_valid) pend_q <= 1'b0;
      if (trig_valid) begin
        state_q   <= ST_STREAM;
        ptr_q     <= trig_ptr;
        discard_q <= (pend_q && !log_rsp_valid) || ev_logreq;
      end else begin
        if (log_rsp_valid) discard_q <= 1'b0;
        if (ev_logreq)     ptr_q <= ptr_q + PTR_W'(BLK);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dmd_hit_q  <= 1'b0;
      dmd_data_q <= '0;
    end else begin
      dmd_hit_q <= buf_hit;
      if (buf_hit) dmd_data_q <= buf_data;
    end
  end

  assign log_req_valid = ev_logreq;
  assign log_req_ptr   = ptr_q;
  assign pf_req_valid  = ev_issue;
  assign pf_req_addr   = q_head_addr;
  assign pf_req_tag    = free_tag;
  assign dmd_hit       = dmd_hit_q;
  assign dmd_data      = dmd_data_q;

  assert_one_log_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    log_req_valid |=> !log_req_valid);

  assert_trigger_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> (q_count == '0));

  assert_restart_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> (log_req_ptr == $past(trig_ptr)));

  assert_hold_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_head_valid && q_head_end && !ev_resume && !trig_valid) |=> (q_count >= $past(q_count)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!log_req_valid && !pf_req_valid));

endmodule

// File: tb/stream_prefetch_engine_tb.sv
`timescale 1ns/1ps
module stream_prefetch_engine_tb_top;
  localparam int AW = 32, PW = 12, DW = 512, BLK = 4, NOUT = 4, TW = 2, NBUF = 32, LOW = 4;
  localparam int LOGN = 4096, RUN_CYCLES = 2400;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic trig_valid = 1'b0;
  logic [PW-1:0] trig_ptr = '0;
  logic log_req_valid;
  logic [PW-1:0] log_req_ptr;
  logic log_rsp_valid = 1'b0;
  logic [BLK*AW-1:0] log_rsp_addr = '0;
  logic [BLK-1:0] log_rsp_end = '0;
  logic pf_req_valid;
  logic [AW-1:0] pf_req_addr;
  logic [TW-1:0] pf_req_tag;
  logic pf_rsp_valid = 1'b0;
  logic [TW-1:0] pf_rsp_tag = '0;
  logic [DW-1:0] pf_rsp_data = '0;
  logic dmd_valid = 1'b0;
  logic [AW-1:0] dmd_addr = '0;
  logic dmd_hit;
  logic [DW-1:0] dmd_data;

  stream_prefetch_engine dut_i (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ptr(trig_ptr),
    .log_req_valid(log_req_valid), .log_req_ptr(log_req_ptr),
    .log_rsp_valid(log_rsp_valid), .log_rsp_addr(log_rsp_addr), .log_rsp_end(log_rsp_end),
    .pf_req_valid(pf_req_valid), .pf_req_addr(pf_req_addr), .pf_req_tag(pf_req_tag),
    .pf_rsp_valid(pf_rsp_valid), .pf_rsp_tag(pf_rsp_tag), .pf_rsp_data(pf_rsp_data),
    .dmd_valid(dmd_valid), .dmd_addr(dmd_addr), .dmd_hit(dmd_hit), .dmd_data(dmd_data));

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // ---------------- reference model state ----------------
  bit m_active = 0, m_pend = 0, m_disc = 0, m_fresh = 0;
  int m_ptr = 0;
  logic [AW-1:0] mq_addr[$];
  bit mq_end[$];
  bit m_busy[NOUT];
  logic [AW-1:0] m_slot[NOUT];
  logic [AW-1:0] mbuf[$];
  bit e_hit = 0;
  logic [AW-1:0] e_addr = '0;
  string e_lbl = "R1";
  logic [AW-1:0] last_evicted = '0;
  bit have_evicted = 0;

  // ---------------- bench memory state ----------------
  bit lr_pend = 0;
  int lr_ptr = 0, lr_due = 0;
  int pq_tag[$], pq_due[$];
  logic [31:0] lfsr = 32'h1234_5678;
  bit did_stale = 0;

  function automatic logic [AW-1:0] log_addr(int p);
    return 32'h4000_0000 + 32'(p) * 32'd52;
  endfunction
  function automatic bit log_end(int p);
    return (p % 29) == 28;
  endfunction
  function automatic logic [DW-1:0] mkdata(logic [AW-1:0] a);
    logic [DW-1:0] d;
    for (int k = 0; k < DW / 32; k++) d[k*32 +: 32] = a ^ (32'(k) * 32'h0101_0101);
    return d;
  endfunction

  function automatic bit m_logreq();
    return m_active && !m_pend && (mq_addr.size() <= LOW);
  endfunction
  function automatic int m_freetag();
    for (int t = 0; t < NOUT; t++) if (!m_busy[t]) return t;
    return NOUT;
  endfunction
  function automatic bit m_issue();
    return m_active && mq_addr.size() > 0 && !mq_end[0] && (m_freetag() < NOUT);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  // ---------------- model step at the active edge ----------------
  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_pend = 0; m_disc = 0; m_fresh = 0; m_ptr = 0;
      mq_addr.delete(); mq_end.delete(); mbuf.delete();
      for (int t = 0; t < NOUT; t++) m_busy[t] = 0;
      e_hit = 0; e_lbl = "R1";
    end else begin
      bit lr, is, rs, found;
      int tg;
      lr = m_logreq();
      is = m_issue();
      tg = m_freetag();
      rs = mq_addr.size() > 0 && mq_end[0] && dmd_valid && dmd_addr == mq_addr[0];
      // demand lookup sees the buffer before this cycle's insertion (R10)
      e_hit = 0; e_lbl = "R6";
      if (dmd_valid) begin
        found = 0;
        for (int i = 0; i < mbuf.size(); i++) begin
          if (!found && mbuf[i] == dmd_addr) begin
            found = 1; mbuf.delete(i);
          end
        end
        if (found) begin
          e_hit = 1; e_addr = dmd_addr; e_lbl = pf_rsp_valid ? "R9" : "R6";
        end else if (have_evicted && dmd_addr == last_evicted) e_lbl = "R7";
        else if (pf_rsp_valid && dmd_addr == m_slot[pf_rsp_tag]) e_lbl = "R10";
      end
      // insertion after the hit removal, oldest dropped only if still full
      if (pf_rsp_valid) begin
        m_busy[pf_rsp_tag] = 0;
        if (mbuf.size() == NBUF) begin
          last_evicted = mbuf.pop_front(); have_evicted = 1;
        end
        mbuf.push_back(m_slot[pf_rsp_tag]);
      end
      if (is) begin
        m_busy[tg] = 1; m_slot[tg] = mq_addr[0];
        void'(mq_addr.pop_front()); void'(mq_end.pop_front());
      end else if (rs) begin
        void'(mq_addr.pop_front()); void'(mq_end.pop_front());
      end
      if (trig_valid) begin
        mq_addr.delete(); mq_end.delete();
        m_disc = (m_pend && !log_rsp_valid) || lr;
        if (lr) m_pend = 1; else if (log_rsp_valid) m_pend = 0;
        m_ptr = int'(trig_ptr); m_active = 1; m_fresh = 1;
      end else begin
        if (log_rsp_valid) begin
          if (!m_disc) begin
            for (int i = 0; i < BLK; i++) begin
              mq_addr.push_back(log_rsp_addr[i*AW +: AW]);
              mq_end.push_back(log_rsp_end[i]);
            end
          end
          m_disc = 0; m_pend = 0;
        end
        if (lr) begin
          m_pend = 1; m_ptr = (m_ptr + BLK) % LOGN; m_fresh = 0;
        end
      end
    end
  end

  // ---------------- compare, memory responders, stimulus ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      string lg, lp;
      int r;
      bit mlr, mis;
      int mtg;
      cyc++;
      mlr = m_logreq(); mis = m_issue(); mtg = m_freetag();
      lg = !m_active ? "R1" : (m_fresh ? "R2" : "R3");
      lp = !m_active ? "R1" : ((mq_addr.size() > 0 && mq_end[0]) ? "R8" : "R4");
      chk(log_req_valid == mlr, lg, "log_req_valid", DW'(log_req_valid), DW'(mlr));
      if (mlr) chk(log_req_ptr == PW'(m_ptr), lg, "log_req_ptr", DW'(log_req_ptr), DW'(m_ptr));
      chk(pf_req_valid == mis, lp, "pf_req_valid", DW'(pf_req_valid), DW'(mis));
      if (mis) begin
        chk(pf_req_addr == mq_addr[0], "R4", "pf_req_addr", DW'(pf_req_addr), DW'(mq_addr[0]));
        chk(pf_req_tag == TW'(mtg), "R4", "pf_req_tag", DW'(pf_req_tag), DW'(mtg));
      end
      chk(dmd_hit == e_hit, m_active ? e_lbl : "R1", "dmd_hit", DW'(dmd_hit), DW'(e_hit));
      if (e_hit) chk(dmd_data == mkdata(e_addr), "R5", "dmd_data", dmd_data, mkdata(e_addr));

      // log memory: three-cycle latency, one read at a time (R3)
      log_rsp_valid = 0;
      if (lr_pend && cyc >= lr_due) begin
        log_rsp_valid = 1;
        for (int i = 0; i < BLK; i++) begin
          log_rsp_addr[i*AW +: AW] = log_addr((lr_ptr + i) % LOGN);
          log_rsp_end[i] = log_end((lr_ptr + i) % LOGN);
        end
        lr_pend = 0;
      end
      if (mlr) begin
        lr_pend = 1; lr_ptr = m_ptr; lr_due = cyc + 3;
      end

      // line memory: latency depends on tag and time, so order varies (R5)
      pf_rsp_valid = 0;
      for (int i = 0; i < pq_tag.size(); i++) begin
        if (!pf_rsp_valid && pq_due[i] <= cyc) begin
          pf_rsp_valid = 1;
          pf_rsp_tag = TW'(pq_tag[i]);
          pf_rsp_data = mkdata(m_slot[pq_tag[i]]);
          pq_tag.delete(i); pq_due.delete(i);
        end
      end
      if (mis) begin
        pq_tag.push_back(mtg);
        pq_due.push_back(cyc + 1 + ((mtg * 3 + cyc) % 5));
      end

      // triggers: start, two restarts, one with a log read in flight (R2)
      trig_valid = 0;
      if (cyc == 5) begin trig_valid = 1; trig_ptr = PW'(0); end
      else if (cyc == 600) begin trig_valid = 1; trig_ptr = PW'(1000); end
      else if (cyc == 1200) begin trig_valid = 1; trig_ptr = PW'(2000); end
      else if (cyc >= 1800 && !did_stale && lr_pend && !log_rsp_valid && !mlr) begin
        trig_valid = 1; trig_ptr = PW'(3000); did_stale = 1;
      end

      // demands
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r = int'(lfsr[15:0]);
      dmd_valid = 0;
      if (mq_addr.size() > 0 && mq_end[0] && r % 8 == 0) begin
        dmd_valid = 1; dmd_addr = mq_addr[0];                 // R8 resume
      end else if (pf_rsp_valid && r % 4 == 1) begin
        dmd_valid = 1; dmd_addr = m_slot[pf_rsp_tag];         // R10 collision
      end else if (mbuf.size() > 0 && r % 3 == 0) begin
        dmd_valid = 1; dmd_addr = mbuf[(r / 3) % mbuf.size()]; // R6/R9 hit
      end else if (r % 7 == 2) begin
        dmd_valid = 1;
        dmd_addr = have_evicted ? last_evicted : (32'hdead_0000 + 32'(cyc)); // R7 miss
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    wait (cyc >= RUN_CYCLES);
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule